// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block keeps the programmable state of a small group of DMA channels. Each channel has a 16-bit start address, a 16-bit transfer length, a live address latched at programming time, and a progress counter. The progress counter is advanced by the transfer engine, one transfer unit per pulse. The host reaches all of it through an 8-bit port. A single byte-order toggle is shared by every channel register, so each 16-bit value is moved as a low byte followed by a high byte. Writing a high byte re-arms the channel: the live address is loaded from the start address and progress returns to zero.

Readback is derived from the stored values rather than from separate down-counters. Reading the address register returns the live address moved forward by the progress count, or moved back by it when the channel runs in decrement mode. Reading the count register returns the programmed length less the progress count. A word-wide build shifts the port index right by one and scales addresses, counts and progress by two, so that one unit is two bytes. The byte toggle can be forced back to the low byte by a strobe from the neighbouring control block.

Top module: `dma_chan_regs`

## Requirements
- R1: After a synchronous reset, all start addresses, lengths, live addresses and progress counts are zero, the byte toggle selects the low byte, and `host_rdata` is 0.
- R2: The 4-bit index is `host_addr[SHIFT+3:SHIFT]`. Index bits 3:1 give the channel and bit 0 selects the register (0 = address, 1 = count). An access to a channel number at or above `NUM_CH` changes no state and does not move the toggle.
- R3: Every accepted read or write of a channel register flips the byte toggle. The value before the flip picks the byte: 0 = bits 7:0, 1 = bits 15:8. When `host_wr` and `host_rd` are both high, only the write is performed.
- R4: A low-byte write replaces bits 7:0 of the selected start address or length and keeps bits 15:8. A high-byte write replaces bits 15:8 and keeps bits 7:0.
- R5: A high-byte write to either register of a channel loads that channel's live address from its (updated) start address scaled by 2^SHIFT and clears its progress count. A low-byte write does neither.
- R6: A count read returns a byte of (length × 2^SHIFT − progress), modulo 2^(16+SHIFT), taken at bit offset SHIFT (low byte) or SHIFT+8 (high byte).
- R7: An address read returns a byte, at the same offsets, of (live address + progress). When the channel's `ch_dec` bit is 1 it is (live address − progress) instead. Both are modulo 2^(16+SHIFT).
- R8: With `WIDE`=1, SHIFT is 1. The index comes from `host_addr[4:1]`, and addresses, lengths and progress steps are scaled by two.
- R9: `clr_ptr` forces the toggle to the low byte on the next edge. This overrides the flip from an access in the same cycle, which still uses the toggle value it saw.
- R10: `xfer_inc` adds 2^SHIFT to the progress count of channel `xfer_ch`. A high-byte write to the same channel in the same cycle wins, and progress becomes zero.
- R11: `host_rdata` is registered. It takes the read byte on the edge that accepts a read and keeps its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 4+SHIFT | Host port address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read byte |
| clr_ptr | input | 1 | Force byte toggle to low byte |
| ch_dec | input | NUM_CH | Per-channel decrement-mode bit |
| xfer_inc | input | 1 | Progress pulse from the transfer engine |
| xfer_ch | input | CHI | Channel advanced by `xfer_inc` |

## Verification
The bench runs a narrow and a word-wide instance side by side against a behavioural model. It goes after the toggle: a design that did not flip it on reads, or flipped it on out-of-range channels, would return swapped bytes from then on. Same-cycle collisions are driven on purpose: a clear strobe with an access, a progress pulse with a high-byte write, and a read with a write. Getting the priority wrong in any of them leaves stale progress or a misaligned toggle. Decrement-mode reads and wrap-around of length minus progress are checked as well, along with low-byte writes that must not re-arm the channel. Any of these errors shows up as a wrong readback byte.

// File: rtl/dmaregs_pkg.sv
package dmaregs_pkg;
  localparam int IDX_W = 4;

  typedef enum logic {
    SEL_ADDR  = 1'b0,
    SEL_COUNT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic ptr_q
);
  always_ff @(posedge clk) begin
    if (rst)       ptr_q <= 1'b0;
    else if (clr)  ptr_q <= 1'b0;
    else if (step) ptr_q <= ~ptr_q;
  end
endmodule

// File: rtl/dma_chan_bank.sv
module dma_chan_bank
  import dmaregs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SHIFT  = 0,
  parameter int CHI    = 2,
  localparam int VW    = 16 + SHIFT
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [CHI-1:0]               wr_ch,
  input  reg_sel_e                     wr_sel,
  input  logic                         wr_hi,
  input  logic [7:0]                   wdata,
  input  logic                         inc_en,
  input  logic [CHI-1:0]               inc_ch,
  output logic [NUM_CH-1:0][15:0]      base_cnt_o,
  output logic [NUM_CH-1:0][VW-1:0]    cur_o,
  output logic [NUM_CH-1:0][VW-1:0]    prog_o
);
  localparam logic [VW-1:0] STEP = VW'(1) << SHIFT;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [15:0]   base_a_q, base_c_q, base_a_nx;
    logic [VW-1:0] cur_q, prog_q;
    logic          hit, rearm, bump;

    assign hit   = wr_en && (wr_ch == CHI'(g));
    assign rearm = hit && wr_hi;
    assign bump  = inc_en && (inc_ch == CHI'(g));

    always_comb begin
      base_a_nx = base_a_q;
      if (hit && wr_sel == SEL_ADDR) begin
        if (wr_hi) base_a_nx[15:8] = wdata;
        else       base_a_nx[7:0]  = wdata;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        base_a_q <= '0;
        base_c_q <= '0;
        cur_q    <= '0;
        prog_q   <= '0;
      end else begin
        base_a_q <= base_a_nx;
        if (hit && wr_sel == SEL_COUNT) begin
          if (wr_hi) base_c_q[15:8] <= wdata;
          else       base_c_q[7:0]  <= wdata;
        end
        if (rearm) begin
          cur_q  <= VW'(base_a_nx) << SHIFT;
          prog_q <= '0;
        end else if (bump) begin
          prog_q <= prog_q + STEP;
        end
      end
    end

    assign base_cnt_o[g] = base_c_q;
    assign cur_o[g]      = cur_q;
    assign prog_o[g]     = prog_q;
  end
endmodule

// File: rtl/dma_readback.sv
module dma_readback
  import dmaregs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SHIFT  = 0,
  parameter int CHI    = 2,
  localparam int VW    = 16 + SHIFT
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_en,
  input  logic [CHI-1:0]            rd_ch,
  input  reg_sel_e                  rd_sel,
  input  logic                      rd_hi,
  input  logic [NUM_CH-1:0]         dec,
  input  logic [NUM_CH-1:0][15:0]   base_cnt,
  input  logic [NUM_CH-1:0][VW-1:0] cur,
  input  logic [NUM_CH-1:0][VW-1:0] prog,
  output logic [7:0]                rdata_q
);
  logic [VW-1:0] val, shifted;

  always_comb begin
    if (rd_sel == SEL_COUNT)
      val = (VW'(base_cnt[rd_ch]) << SHIFT) - prog[rd_ch];
    else if (dec[rd_ch])
      val = cur[rd_ch] - prog[rd_ch];
    else
      val = cur[rd_ch] + prog[rd_ch];
    shifted = val >> (SHIFT + (rd_hi ? 8 : 0));
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= shifted[7:0];
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dmaregs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter bit WIDE   = 1'b0,
  localparam int SHIFT = WIDE ? 1 : 0,
  localparam int VW    = 16 + SHIFT,
  localparam int CHI   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [IDX_W+SHIFT-1:0] host_addr,
  input  logic                  host_wr,
  input  logic                  host_rd,
  input  logic [7:0]            host_wdata,
  output logic [7:0]            host_rdata,
  input  logic                  clr_ptr,
  input  logic [NUM_CH-1:0]     ch_dec,
  input  logic                  xfer_inc,
  input  logic [CHI-1:0]        xfer_ch
);
  logic [IDX_W-1:0]           idx;
  logic [2:0]                 ch_full;
  logic [CHI-1:0]             ch;
  reg_sel_e                   sel;
  logic                       acc_ok, wr_fire, rd_fire, ptr_q;
  logic [NUM_CH-1:0][15:0]    base_cnt;
  logic [NUM_CH-1:0][VW-1:0]  cur, prog;
  logic [NUM_CH*VW-1:0]       prog_flat;

  assign idx       = host_addr[SHIFT +: IDX_W];
  assign ch_full   = idx[3:1];
  assign ch        = ch_full[CHI-1:0];
  assign sel       = reg_sel_e'(idx[0]);
  assign acc_ok    = (int'(ch_full) < NUM_CH);
  assign wr_fire   = host_wr && acc_ok;
  assign rd_fire   = host_rd && !host_wr && acc_ok;
  assign prog_flat = prog;

  dma_byte_ptr u_ptr (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr_ptr),
    .step  (wr_fire || rd_fire),
    .ptr_q (ptr_q)
  );

  dma_chan_bank #(.NUM_CH(NUM_CH), .SHIFT(SHIFT), .CHI(CHI)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_fire),
    .wr_ch      (ch),
    .wr_sel     (sel),
    .wr_hi      (ptr_q),
    .wdata      (host_wdata),
    .inc_en     (xfer_inc),
    .inc_ch     (xfer_ch),
    .base_cnt_o (base_cnt),
    .cur_o      (cur),
    .prog_o     (prog)
  );

  dma_readback #(.NUM_CH(NUM_CH), .SHIFT(SHIFT), .CHI(CHI)) u_rb (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_fire),
    .rd_ch    (ch),
    .rd_sel   (sel),
    .rd_hi    (ptr_q),
    .dec      (ch_dec),
    .base_cnt (base_cnt),
    .cur      (cur),
    .prog     (prog),
    .rdata_q  (host_rdata)
  );
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int NUM_CH = 4,
  parameter int VW     = 16,
  parameter int CHI    = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 clr_ptr,
  input logic                 wr_fire,
  input logic                 rd_fire,
  input logic                 ptr_q,
  input logic [CHI-1:0]       ch,
  input logic [7:0]           host_rdata,
  input logic [NUM_CH*VW-1:0] prog_flat
);
  logic [CHI-1:0] ch_q;
  always_ff @(posedge clk) ch_q <= ch;

  AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr_ptr |=> !ptr_q); // R9
  AST_PTR_FLIPS: assert property (@(posedge clk) disable iff (rst)
    ((wr_fire || rd_fire) && !clr_ptr) |=> (ptr_q != $past(ptr_q))); // R3
  AST_PTR_STILL: assert property (@(posedge clk) disable iff (rst)
    (!wr_fire && !rd_fire && !clr_ptr) |=> $stable(ptr_q)); // R3
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !rd_fire |=> $stable(host_rdata)); // R11
  AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && ptr_q) |=> (prog_flat[ch_q*VW +: VW] == '0)); // R5
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NUM_CH(NUM_CH), .VW(VW), .CHI(CHI)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr_ptr    (clr_ptr),
  .wr_fire    (wr_fire),
  .rd_fire    (rd_fire),
  .ptr_q      (ptr_q),
  .ch         (ch),
  .host_rdata (host_rdata),
  .prog_flat  (prog_flat)
);

// File: tb/dma_chan_regs_tb_top.sv
module dma_chan_regs_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic [3:0] idx = '0;
  logic       wr = 1'b0, rd = 1'b0, clr = 1'b0, inc = 1'b0;
  logic [7:0] wd = '0;
  logic [3:0] dec = '0;
  logic [1:0] xch = '0;
  logic [7:0] rd_n, rd_w;

  dma_chan_regs #(.NUM_CH(4), .WIDE(1'b0)) dut_i (
    .clk(clk), .rst(rst), .host_addr(idx), .host_wr(wr), .host_rd(rd),
    .host_wdata(wd), .host_rdata(rd_n), .clr_ptr(clr), .ch_dec(dec),
    .xfer_inc(inc), .xfer_ch(xch));

  dma_chan_regs #(.NUM_CH(4), .WIDE(1'b1)) dut_w (
    .clk(clk), .rst(rst), .host_addr({idx, 1'b0}), .host_wr(wr), .host_rd(rd),
    .host_wdata(wd), .host_rdata(rd_w), .clr_ptr(clr), .ch_dec(dec),
    .xfer_inc(inc), .xfer_ch(xch));

  // behavioural model, index 0 = narrow, 1 = word-wide
  int mba[2][4], mbc[2][4], mcur[2][4], mprog[2][4];
  int mptr[2], mrd[2];
  int total = 0, bad = 0;
  bit done = 0;
  string req = "R1";

  task automatic model_step(input int k);
    int sh, msk, ch, hi, val;
    bit ok;
    sh = k; msk = (1 << (16 + sh)) - 1;
    if (rst) begin
      for (int c = 0; c < 4; c++) begin
        mba[k][c] = 0; mbc[k][c] = 0; mcur[k][c] = 0; mprog[k][c] = 0;
      end
      mptr[k] = 0; mrd[k] = 0;
      return;
    end
    ch = int'(idx) >> 1; ok = ch < 4; hi = mptr[k];
    if (rd && !wr && ok) begin
      if (idx[0]) val = ((mbc[k][ch] << sh) - mprog[k][ch]) & msk;
      else if (dec[ch]) val = (mcur[k][ch] - mprog[k][ch]) & msk;
      else val = (mcur[k][ch] + mprog[k][ch]) & msk;
      mrd[k] = (val >> (sh + 8 * hi)) & 255;
    end
    if (inc && !(wr && ok && hi == 1 && ch == int'(xch)))
      mprog[k][xch] = (mprog[k][xch] + (1 << sh)) & msk;
    if (wr && ok) begin
      if (idx[0] == 1'b0) begin
        if (hi == 1) mba[k][ch] = (mba[k][ch] & 255) | (int'(wd) << 8);
        else         mba[k][ch] = (mba[k][ch] & 16'hff00) | int'(wd);
      end else begin
        if (hi == 1) mbc[k][ch] = (mbc[k][ch] & 255) | (int'(wd) << 8);
        else         mbc[k][ch] = (mbc[k][ch] & 16'hff00) | int'(wd);
      end
      if (hi == 1) begin
        mcur[k][ch] = (mba[k][ch] << sh) & msk;
        mprog[k][ch] = 0;
      end
    end
    if (clr) mptr[k] = 0;
    else if ((wr || rd) && ok) mptr[k] = 1 - mptr[k];
  endtask

  always @(posedge clk) begin
    model_step(0);
    model_step(1);
  end

  always @(negedge clk) begin
    if (!done) begin
      total += 2;
      if (int'(rd_n) != mrd[0]) begin
        bad++;
        $display("FAIL %s narrow: host_rdata=%0h expected=%0h", req, rd_n, mrd[0]);
      end
      if (int'(rd_w) != mrd[1]) begin
        bad++;
        $display("FAIL %s with R8 word-wide: host_rdata=%0h expected=%0h", req, rd_w, mrd[1]);
      end
    end
  end

  task automatic cyc(input bit w, input bit r, input int i, input int d,
                     input bit c = 0, input bit n = 0, input int x = 0);
    @(negedge clk);
    wr = w; rd = r; idx = 4'(i); wd = 8'(d); clr = c; inc = n; xch = 2'(x);
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) cyc(0, 0, 0, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    idle(3);
    @(negedge clk); rst = 1'b0;
    req = "R1";
    for (int i = 0; i < 8; i++) begin cyc(0, 1, i, 0); cyc(0, 1, i, 0); end
    req = "R4";
    cyc(1, 0, 0, 8'h34); cyc(1, 0, 0, 8'h12);
    cyc(1, 0, 1, 8'h10); cyc(1, 0, 1, 8'h00);
    cyc(0, 1, 0, 0); cyc(0, 1, 0, 0); cyc(0, 1, 1, 0); cyc(0, 1, 1, 0);
    req = "R10";
    for (int j = 0; j < 5; j++) cyc(0, 0, 0, 0, 0, 1, 0);
    cyc(0, 1, 0, 0); cyc(0, 1, 0, 0);
    req = "R6";
    cyc(0, 1, 1, 0); cyc(0, 1, 1, 0);
    for (int j = 0; j < 20; j++) cyc(0, 0, 0, 0, 0, 1, 0);
    cyc(0, 1, 1, 0); cyc(0, 1, 1, 0);
    req = "R5";
    cyc(1, 0, 0, 8'hAA);
    cyc(1, 0, 14, 8'h55);
    cyc(0, 1, 0, 0); cyc(0, 1, 0, 0);
    cyc(1, 0, 0, 8'h77); cyc(1, 0, 0, 8'h66);
    cyc(0, 1, 0, 0); cyc(0, 1, 0, 0);
    req = "R7";
    cyc(1, 0, 2, 8'h00); cyc(1, 0, 2, 8'h01);
    for (int j = 0; j < 3; j++) cyc(0, 0, 0, 0, 0, 1, 1);
    dec = 4'b0010;
    cyc(0, 1, 2, 0); cyc(0, 1, 2, 0);
    dec = 4'b0000;
    cyc(0, 1, 2, 0); cyc(0, 1, 2, 0);
    req = "R9";
    cyc(0, 1, 4, 0); cyc(0, 0, 0, 0, 1);
    cyc(0, 1, 4, 0); cyc(0, 1, 4, 0, 1);
    cyc(0, 1, 4, 0); cyc(0, 1, 4, 0);
    req = "R2";
    cyc(1, 0, 9, 8'hEE); cyc(0, 1, 12, 0); cyc(1, 0, 15, 8'h11);
    cyc(0, 1, 0, 0); cyc(0, 1, 0, 0);
    req = "R3";
    cyc(1, 1, 6, 8'h21); cyc(1, 1, 6, 8'h43);
    cyc(0, 1, 6, 0); idle(2); cyc(0, 1, 6, 0);
    req = "R10";
    cyc(0, 0, 0, 0, 0, 1, 3); cyc(1, 0, 6, 8'h09);
    cyc(1, 0, 6, 8'h80, 0, 1, 3);
    cyc(0, 1, 6, 0); cyc(0, 1, 6, 0);
    req = "R11";
    idle(4);
    req = "R8";
    for (int j = 0; j < 3000; j++) begin
      if (j % 200 == 0) dec = 4'($urandom);
      cyc(($urandom % 4) == 0, ($urandom % 3) == 0, int'($urandom % 16),
          int'($urandom % 256), ($urandom % 16) == 0, ($urandom % 3) == 0,
          int'($urandom % 4));
    end
    idle(3);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule